// File: doc/BRIEF.md
# Variable-Page-Size Fully Associative Translation Buffer

This block is a translation buffer in which every entry is searched at once. Each entry holds a virtual page tag, a 13-bit context and a translation with these fields: valid, page size, global, privileged, writable, used and physical page number. Each entry compares the incoming virtual page number under a mask set by its own page size. As a result, 8 KB, 64 KB, 512 KB and 4 MB mappings can sit side by side in the same array.

A lookup supplies the virtual page number (address bits 63:13), a context, an instruction-fetch flag, a flag for a trap level above zero, a user flag and a write flag. One cycle later the block reports exactly one outcome: a successful hit with a 41-bit physical address, a miss, a privilege fault or a protection fault. On a miss or a fault, a tag-access register captures the failing page number together with the context that was used, so that refill software can use it. Entries are loaded by index through a write port. The choice of victim and the refill itself are left to the surrounding logic.

Top module: `vpt_tlb`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid` is 0 and `tag_access` is 0, so any lookup then misses.
- R2: An entry matches when it is valid, its tag equals the looked-up page number on the compared bits, and either its global bit is set or its context equals the effective lookup context. Writing an entry with valid 0 removes it.
- R3: Page size code s selects which bits are compared. Code 0 is 8 KB, 1 is 64 KB, 2 is 512 KB and 3 is 4 MB. Tag bits below bit 3*s of the page number (address bit 13+3s) are ignored.
- R4: On a hit, `rsp_pa` takes the entry's physical page bits at and above address bit 13+3s and the lookup address bits below that. It is truncated to 41 bits, and bits 12:0 are 0.
- R5: A match on a privileged entry during a user access gives a privilege fault. This takes precedence over a protection fault.
- R6: A write that matches an entry whose writable bit is clear, with no privilege fault, gives a protection fault. A read of that entry hits.
- R7: A successful hit sets the entry's used bit. `rsp_first_use` is 1 on a hit whose entry had used clear, and 0 otherwise. Writing an entry clears its used bit. Faults leave the used bit unchanged.
- R8: On a miss or a fault, `tag_access` becomes {page number, 13-bit effective context}. On a hit it keeps its value.
- R9: For an instruction fetch with the trap-level flag set, the effective context is 0. Otherwise it is `lk_ctx`. The trap-level flag has no effect on data lookups.
- R10: If several entries match, the lowest-indexed entry decides the outcome and the address.
- R11: Results appear in the cycle after `lk_valid`, with exactly one outcome flag set. An entry written in the same cycle as a lookup is not seen by that lookup, but is seen by the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load entry `wr_idx` |
| wr_idx | input | 6 | Entry index to load |
| wr_valid | input | 1 | Valid bit of the loaded entry |
| wr_size | input | 2 | Page size code (0 = 8K, 1 = 64K, 2 = 512K, 3 = 4M) |
| wr_global | input | 1 | Entry matches any context |
| wr_priv | input | 1 | Entry is privileged-only |
| wr_writable | input | 1 | Entry permits writes |
| wr_vtag | input | 51 | Virtual page tag (address bits 63:13) |
| wr_ctx | input | 13 | Entry context |
| wr_ppn | input | 28 | Physical page number (address bits 40:13) |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 51 | Lookup address bits 63:13 |
| lk_ctx | input | 13 | Lookup context |
| lk_ifetch | input | 1 | Lookup is an instruction fetch |
| lk_tl_nz | input | 1 | Trap level above zero |
| lk_user | input | 1 | User-mode access |
| lk_write | input | 1 | Write access |
| rsp_valid | output | 1 | Result valid |
| rsp_hit | output | 1 | Successful translation |
| rsp_miss | output | 1 | No entry matched |
| rsp_priv_fault | output | 1 | Privilege fault |
| rsp_prot_fault | output | 1 | Protection fault |
| rsp_first_use | output | 1 | Hit entry had used bit clear |
| rsp_pa | output | 41 | Physical address |
| tag_access | output | 64 | Last missing or faulting page number and context |

## Verification
Every result register sits one clock edge after the lookup. The bench drives a request at a falling edge and reads the outcome flags, `rsp_pa`, `rsp_first_use` and `tag_access` at the next falling edge. By then exactly one rising edge has registered them. An entry write takes effect at the same rising edge, so a lookup driven in the write's cycle is checked against the table as it was before the write. The bench's model applies the write only after it has computed that lookup's expected result.

// File: rtl/vpt_pkg.sv
package vpt_pkg;
  localparam int unsigned PAGE_LSB = 13;

  typedef enum logic [1:0] {
    PG_8K   = 2'd0,
    PG_64K  = 2'd1,
    PG_512K = 2'd2,
    PG_4M   = 2'd3
  } pg_size_e;

  // number of ignored low page-number bits for a size code
  function automatic int unsigned pg_span(input logic [1:0] code);
    case (pg_size_e'(code))
      PG_8K:   return 0;
      PG_64K:  return 3;
      PG_512K: return 6;
      default: return 9;
    endcase
  endfunction
endpackage

// File: rtl/vpt_page_mask.sv
module vpt_page_mask
  import vpt_pkg::*;
#(
  parameter int unsigned W = 51
) (
  input  logic [1:0]   size,
  output logic [W-1:0] keep
);
  always_comb begin
    for (int unsigned j = 0; j < W; j++) begin
      keep[j] = (j >= pg_span(size));
    end
  end
endmodule

// File: rtl/vpt_entry_match.sv
module vpt_entry_match #(
  parameter int unsigned TAG_W = 51,
  parameter int unsigned CTX_W = 13
) (
  input  logic             e_valid,
  input  logic [1:0]       e_size,
  input  logic             e_global,
  input  logic [TAG_W-1:0] e_vtag,
  input  logic [CTX_W-1:0] e_ctx,
  input  logic [TAG_W-1:0] q_vpn,
  input  logic [CTX_W-1:0] q_ctx,
  output logic             hit
);
  logic [TAG_W-1:0] keep;
  logic             tag_eq;
  logic             ctx_ok;

  vpt_page_mask #(.W(TAG_W)) u_mask (
    .size (e_size),
    .keep (keep)
  );

  always_comb begin
    tag_eq = (((e_vtag ^ q_vpn) & keep) == '0);
    ctx_ok = e_global || (e_ctx == q_ctx);
    hit    = e_valid && tag_eq && ctx_ok;
  end
endmodule

// File: rtl/vpt_first_hit.sv
module vpt_first_hit #(
  parameter int unsigned N     = 64,
  parameter int unsigned IDX_W = 6
) (
  input  logic [N-1:0]     hits,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vpt_tlb.sv
module vpt_tlb
  import vpt_pkg::*;
#(
  parameter int unsigned N_ENT = 64,
  parameter int unsigned VA_W  = 64,
  parameter int unsigned PA_W  = 41,
  parameter int unsigned CTX_W = 13
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [$clog2(N_ENT)-1:0]          wr_idx,
  input  logic                              wr_valid,
  input  logic [1:0]                        wr_size,
  input  logic                              wr_global,
  input  logic                              wr_priv,
  input  logic                              wr_writable,
  input  logic [VA_W-PAGE_LSB-1:0]          wr_vtag,
  input  logic [CTX_W-1:0]                  wr_ctx,
  input  logic [PA_W-PAGE_LSB-1:0]          wr_ppn,
  input  logic                              lk_valid,
  input  logic [VA_W-PAGE_LSB-1:0]          lk_vpn,
  input  logic [CTX_W-1:0]                  lk_ctx,
  input  logic                              lk_ifetch,
  input  logic                              lk_tl_nz,
  input  logic                              lk_user,
  input  logic                              lk_write,
  output logic                              rsp_valid,
  output logic                              rsp_hit,
  output logic                              rsp_miss,
  output logic                              rsp_priv_fault,
  output logic                              rsp_prot_fault,
  output logic                              rsp_first_use,
  output logic [PA_W-1:0]                   rsp_pa,
  output logic [VA_W-1:0]                   tag_access
);
  localparam int unsigned IDX_W = $clog2(N_ENT);
  localparam int unsigned TAG_W = VA_W - PAGE_LSB;
  localparam int unsigned PPN_W = PA_W - PAGE_LSB;

  // ---------------- entry storage ----------------
  logic [N_ENT-1:0] valid_q, valid_d;
  logic [N_ENT-1:0] used_q, used_d;
  logic [N_ENT-1:0] global_q, priv_q, wok_q;
  logic [1:0]       size_q [N_ENT];
  logic [TAG_W-1:0] vtag_q [N_ENT];
  logic [CTX_W-1:0] ctx_q  [N_ENT];
  logic [PPN_W-1:0] ppn_q  [N_ENT];

  // ---------------- lookup datapath ----------------
  logic [CTX_W-1:0] eff_ctx;
  logic [N_ENT-1:0] hits;
  logic             hit_any;
  logic [IDX_W-1:0] hit_idx;
  logic             priv_f, prot_f, good_hit;
  logic [PPN_W-1:0] pa_keep, pa_ppn;

  assign eff_ctx = (lk_ifetch && lk_tl_nz) ? '0 : lk_ctx;

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    vpt_entry_match #(.TAG_W(TAG_W), .CTX_W(CTX_W)) u_match (
      .e_valid  (valid_q[g]),
      .e_size   (size_q[g]),
      .e_global (global_q[g]),
      .e_vtag   (vtag_q[g]),
      .e_ctx    (ctx_q[g]),
      .q_vpn    (lk_vpn),
      .q_ctx    (eff_ctx),
      .hit      (hits[g])
    );
  end

  vpt_first_hit #(.N(N_ENT), .IDX_W(IDX_W)) u_pick (
    .hits (hits),
    .any  (hit_any),
    .idx  (hit_idx)
  );

  vpt_page_mask #(.W(PPN_W)) u_pa_mask (
    .size (size_q[hit_idx]),
    .keep (pa_keep)
  );

  always_comb begin
    priv_f   = hit_any && priv_q[hit_idx] && lk_user;
    prot_f   = hit_any && !priv_f && lk_write && !wok_q[hit_idx];
    good_hit = lk_valid && hit_any && !priv_f && !prot_f;
    pa_ppn   = (ppn_q[hit_idx] & pa_keep) | (lk_vpn[PPN_W-1:0] & ~pa_keep);
  end

  // ---------------- entry state next-state ----------------
  always_comb begin
    valid_d = valid_q;
    used_d  = used_q;
    if (good_hit) used_d[hit_idx] = 1'b1;
    if (wr_en) begin
      valid_d[wr_idx] = wr_valid;
      used_d[wr_idx]  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      used_q  <= '0;
    end else begin
      valid_q <= valid_d;
      used_q  <= used_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      global_q[wr_idx] <= wr_global;
      priv_q[wr_idx]   <= wr_priv;
      wok_q[wr_idx]    <= wr_writable;
      size_q[wr_idx]   <= wr_size;
      vtag_q[wr_idx]   <= wr_vtag;
      ctx_q[wr_idx]    <= wr_ctx;
      ppn_q[wr_idx]    <= wr_ppn;
    end
  end

  // ---------------- response next-state ----------------
  logic             hit_d, miss_d, pf_d, wf_d, fu_d, ta_en;
  logic [PA_W-1:0]  pa_d;
  logic [VA_W-1:0]  ta_d;

  always_comb begin
    hit_d = good_hit;
    miss_d = lk_valid && !hit_any;
    pf_d  = lk_valid && priv_f;
    wf_d  = lk_valid && prot_f;
    fu_d  = good_hit && !used_q[hit_idx];
    pa_d  = {pa_ppn, {PAGE_LSB{1'b0}}};
    ta_d  = {lk_vpn, PAGE_LSB'(eff_ctx)};
    ta_en = lk_valid && !good_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_miss       <= 1'b0;
      rsp_priv_fault <= 1'b0;
      rsp_prot_fault <= 1'b0;
      rsp_first_use  <= 1'b0;
      rsp_pa         <= '0;
      tag_access     <= '0;
    end else begin
      rsp_valid      <= lk_valid;
      rsp_hit        <= hit_d;
      rsp_miss       <= miss_d;
      rsp_priv_fault <= pf_d;
      rsp_prot_fault <= wf_d;
      rsp_first_use  <= fu_d;
      if (good_hit) rsp_pa     <= pa_d;
      if (ta_en)    tag_access <= ta_d;
    end
  end

  // ---------------- assertions ----------------
  assert_req_to_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  assert_idle_no_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_priv_fault, rsp_prot_fault}) == 1);
  assert_priv_user_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_priv_fault |-> $past(lk_user));
  assert_prot_write_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_prot_fault |-> $past(lk_write));
  assert_tag_hold_on_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> $stable(tag_access));
  assert_first_use_on_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_first_use |-> rsp_hit);
  assert_pick_lowest_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |-> (hits[hit_idx] && ((hits & ((N_ENT'(1) << hit_idx) - N_ENT'(1))) == '0)));
endmodule

// File: tb/vpt_tlb_tb_top.sv
`timescale 1ns/1ps
module vpt_tlb_tb_top;
  localparam int N = 64, SH = 13, CW = 13;
  localparam int TW = 64 - SH, PW = 41 - SH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          wr_en = 0, wr_valid = 0, wr_global = 0, wr_priv = 0, wr_writable = 0;
  logic [5:0]    wr_idx = '0;
  logic [1:0]    wr_size = '0;
  logic [TW-1:0] wr_vtag = '0;
  logic [CW-1:0] wr_ctx = '0;
  logic [PW-1:0] wr_ppn = '0;
  logic          lk_valid = 0, lk_ifetch = 0, lk_tl_nz = 0, lk_user = 0, lk_write = 0;
  logic [TW-1:0] lk_vpn = '0;
  logic [CW-1:0] lk_ctx = '0;
  logic          rsp_valid, rsp_hit, rsp_miss, rsp_priv_fault, rsp_prot_fault, rsp_first_use;
  logic [40:0]   rsp_pa;
  logic [63:0]   tag_access;

  vpt_tlb dut_i (.*);

  // ---------------- reference model ----------------
  bit          m_valid [N], m_used [N], m_glob [N], m_priv [N], m_wok [N];
  bit [1:0]    m_size [N];
  bit [TW-1:0] m_tag [N];
  bit [CW-1:0] m_ctx [N];
  bit [PW-1:0] m_ppn [N];
  bit [63:0]   exp_ta;
  int n_tests = 0, n_fail = 0;

  task automatic check(string req, logic [127:0] got, logic [127:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic stage(int idx, bit v, bit [1:0] s, bit g, bit p, bit w,
                       bit [TW-1:0] tag, bit [CW-1:0] c, bit [PW-1:0] ppn);
    wr_idx = 6'(idx); wr_valid = v; wr_size = s; wr_global = g; wr_priv = p;
    wr_writable = w; wr_vtag = tag; wr_ctx = c; wr_ppn = ppn;
  endtask

  task automatic commit_model();
    int i = int'(wr_idx);
    m_valid[i] = wr_valid; m_used[i] = 0; m_size[i] = wr_size; m_glob[i] = wr_global;
    m_priv[i] = wr_priv; m_wok[i] = wr_writable; m_tag[i] = wr_vtag;
    m_ctx[i] = wr_ctx; m_ppn[i] = wr_ppn;
  endtask

  task automatic wr_entry(int idx, bit v, bit [1:0] s, bit g, bit p, bit w,
                          bit [TW-1:0] tag, bit [CW-1:0] c, bit [PW-1:0] ppn);
    @(negedge clk);
    stage(idx, v, s, g, p, w, tag, c, ppn);
    commit_model();
    wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  function automatic int find_entry(bit [TW-1:0] vpn, bit [CW-1:0] c);
    for (int i = 0; i < N; i++) begin
      int sh = 3 * int'(m_size[i]);
      if (m_valid[i] && (((m_tag[i] ^ vpn) >> sh) == '0) && (m_glob[i] || m_ctx[i] == c))
        return i;
    end
    return -1;
  endfunction

  // lookup; with_wr also strobes the currently staged write in the same cycle
  task automatic lookup(string req, bit [TW-1:0] vpn, bit [CW-1:0] c, bit ifet, bit tl,
                        bit usr, bit wrt, bit with_wr);
    bit [CW-1:0] ectx;
    int idx;
    bit e_hit, e_miss, e_pf, e_wf, e_fu;
    bit [40:0] e_pa;
    ectx = (ifet && tl) ? '0 : c;
    idx = find_entry(vpn, ectx);
    e_miss = (idx < 0);
    e_pf = !e_miss && m_priv[idx] && usr;
    e_wf = !e_miss && !e_pf && wrt && !m_wok[idx];
    e_hit = !e_miss && !e_pf && !e_wf;
    e_fu = e_hit && !m_used[idx];
    e_pa = '0;
    if (e_hit) begin
      bit [PW-1:0] km = {PW{1'b1}} << (3 * int'(m_size[idx]));
      e_pa = {(m_ppn[idx] & km) | (vpn[PW-1:0] & ~km), 13'd0};
      m_used[idx] = 1;
    end else begin
      exp_ta = {vpn, ectx};
    end
    @(negedge clk);
    lk_vpn = vpn; lk_ctx = c; lk_ifetch = ifet; lk_tl_nz = tl; lk_user = usr;
    lk_write = wrt; lk_valid = 1;
    if (with_wr) begin
      wr_en = 1;
      commit_model();
    end
    @(negedge clk);
    lk_valid = 0; wr_en = 0;
    if (!e_hit) e_pa = rsp_pa;
    check(req, {rsp_valid, rsp_hit, rsp_miss, rsp_priv_fault, rsp_prot_fault, rsp_first_use,
                rsp_pa, tag_access},
               {1'b1, e_hit, e_miss, e_pf, e_wf, e_fu, e_pa, exp_ta});
  endtask

  localparam bit [TW-1:0] T4  = 51'h1_2345_6789_A9FF;
  localparam bit [TW-1:0] T8  = 51'h0_0000_0040_1000;
  localparam bit [TW-1:0] T64 = 51'h0_0000_0080_0000;
  localparam bit [TW-1:0] T512 = 51'h0_0000_00A0_0000;
  localparam bit [TW-1:0] TG  = 51'h0_0000_00C0_0000;
  localparam bit [TW-1:0] TP  = 51'h0_0000_0100_0000;
  localparam bit [TW-1:0] TI  = 51'h0_0000_0140_0000;
  localparam bit [TW-1:0] TQ  = 51'h0_0000_0180_0000;
  localparam bit [TW-1:0] TS  = 51'h0_0000_01C0_0000;

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    int seed_init;
    seed_init = $urandom(32'h1D2C3B);
    exp_ta = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state and empty table
    check("R1", {rsp_valid, tag_access}, {1'b0, 64'd0});
    lookup("R1", T8, 13'd7, 0, 0, 0, 0, 0);

    // R3 / R4: mixed page sizes
    wr_entry(5, 1, 2'd3, 0, 0, 1, T4, 13'd7, 28'hABC_DE55);
    wr_entry(6, 1, 2'd0, 0, 0, 1, T8, 13'd7, 28'h123_4567);
    wr_entry(7, 1, 2'd1, 0, 0, 1, T64, 13'd7, 28'h0F0_F0F7);
    wr_entry(8, 1, 2'd2, 0, 0, 1, T512, 13'd7, 28'h777_7000);
    lookup("R3", {T4[TW-1:9], 9'h0F3}, 13'd7, 0, 0, 0, 0, 0);
    lookup("R3", T4 ^ 51'h200, 13'd7, 0, 0, 0, 0, 0);
    lookup("R4", T8, 13'd7, 0, 0, 0, 0, 0);
    lookup("R3", T8 ^ 51'h1, 13'd7, 0, 0, 0, 0, 0);
    lookup("R4", T64 | 51'h5, 13'd7, 0, 0, 0, 0, 0);
    lookup("R3", T64 | 51'h8, 13'd7, 0, 0, 0, 0, 0);
    lookup("R4", T512 | 51'h2B, 13'd7, 0, 0, 0, 0, 0);
    lookup("R3", T512 | 51'h40, 13'd7, 0, 0, 0, 0, 0);

    // R2: context and global
    lookup("R2", T8, 13'd2, 0, 0, 0, 0, 0);
    wr_entry(9, 1, 2'd0, 1, 0, 1, TG, 13'd9, 28'h0000_ABC);
    lookup("R2", TG, 13'd2, 0, 0, 0, 0, 0);

    // R5 / R6 / R7: privilege, protection, used
    wr_entry(11, 1, 2'd0, 0, 1, 0, TP, 13'd7, 28'h555_5555);
    lookup("R5", TP, 13'd7, 0, 0, 1, 0, 0);
    lookup("R5", TP, 13'd7, 0, 0, 1, 1, 0);
    lookup("R6", TP, 13'd7, 0, 0, 0, 1, 0);
    lookup("R7", TP, 13'd7, 0, 0, 0, 0, 0);
    lookup("R7", TP, 13'd7, 0, 0, 0, 0, 0);
    wr_entry(11, 1, 2'd0, 0, 1, 0, TP, 13'd7, 28'h555_5555);
    lookup("R7", TP, 13'd7, 0, 0, 0, 0, 0);
    lookup("R8", TS, 13'd3, 0, 0, 0, 0, 0);
    lookup("R8", T8, 13'd7, 0, 0, 0, 0, 0);

    // R9: instruction context forcing
    wr_entry(12, 1, 2'd0, 0, 0, 1, TI, 13'd0, 28'h0AA_0AA0);
    lookup("R9", TI, 13'd7, 1, 1, 0, 0, 0);
    lookup("R9", TI, 13'd7, 1, 0, 0, 0, 0);
    lookup("R9", TI, 13'd7, 0, 1, 0, 0, 0);

    // R10: lowest index wins
    wr_entry(20, 1, 2'd0, 0, 0, 1, TQ, 13'd7, 28'h222_2222);
    wr_entry(14, 1, 2'd0, 0, 0, 1, TQ, 13'd7, 28'h444_4444);
    lookup("R10", TQ, 13'd7, 0, 0, 0, 0, 0);

    // R11: write in the lookup cycle is not seen until the next lookup
    stage(40, 1, 2'd0, 0, 0, 1, TS, 13'd3, 28'h0DD_0DD0);
    lookup("R11", TS, 13'd3, 0, 0, 0, 0, 1);
    lookup("R11", TS, 13'd3, 0, 0, 0, 0, 0);

    // R2: invalidation
    wr_entry(6, 0, 2'd0, 0, 0, 1, T8, 13'd7, 28'h123_4567);
    lookup("R2", T8, 13'd7, 0, 0, 0, 0, 0);

    // random phase
    for (int k = 0; k < 600; k++) begin
      bit [TW-1:0] v;
      v = {((($urandom % 2) == 0) ? 40'h12_3456_789A : 40'h00_0000_0001), 11'($urandom)};
      if (($urandom % 3) == 0) begin
        wr_entry(int'($urandom % N), 1'($urandom % 5 != 0), 2'($urandom), 1'($urandom % 4 == 0),
                 1'($urandom % 3 == 0), 1'($urandom % 2), v, 13'($urandom % 4), 28'($urandom));
      end else begin
        lookup("R2", v, 13'($urandom % 4), 1'($urandom), 1'($urandom), 1'($urandom),
               1'($urandom), 0);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule